// File: doc/BRIEF.md
# Strap Capture and Power-Down Clock Sequencer

This block sequences the start and stop of a multi-output clock generator's output groups. One control pin has two roles. While the chip is powering up, a low-to-high transition on it signals that supply levels are good. The block then stores the levels on five frequency-select strap pins and turns those pins around so they can drive clocks. From then on the same pin is an active-low power-down request.

A power-down request is synchronised into the CPU clock domain and takes effect only once it has been seen low on two CPU clock edges in a row. A run enable then goes to every output group. Each group re-times that enable into its own clock domain. It holds it in a latch that is open only while the group clock is low, and ANDs it with the clock. As a result, each group stops low on a falling edge and restarts on a rising edge, and never emits a shortened pulse. The oscillator, PLL and analog shutdown lie outside this block.

Top module: `strap_pd_seq`

## Requirements
- R1: While `rst_n` is low, `fsel_code` is 0, `pins_oe` is 0, every `grp_gate` bit is 0 and every `grp_clk_out` bit is low.
- R2: After reset, while the control pin has not yet gone high, `pins_oe` and `fsel_code` stay 0 and no gated output toggles.
- R3: When the control pin goes high (changed between CPU edges), `strap_in` is stored into `fsel_code` and `pins_oe` rises at the third CPU rising edge after the change. At the second edge both are still 0.
- R4: After capture, `fsel_code` and `pins_oe` do not change for any later pin activity or any `strap_in` change until the next reset.
- R5: After capture, the CPU-clocked group (group 0) gives its first gated high phase at the seventh CPU rising edge after the pin went high, and every group's `grp_gate` later reads 1.
- R6: A low on the control pin seen by only one CPU rising edge is ignored: no gate drops and group 0 keeps every high phase.
- R7: A sustained low on the control pin lets group 0 produce high phases at exactly the first six CPU rising edges after the pin falls, and none after. Every group then settles with `grp_gate` = 0 and its output low.
- R8: A low seen by exactly two CPU rising edges removes exactly one high phase of group 0, the one at the seventh edge after the fall.
- R9: Every high phase on every gated output lasts exactly half its group clock period, so no output ever produces a runt pulse.
- R10: When the pin returns high after a power-down, group 0 gives its first gated high phase at the sixth CPU rising edge after the rise, and every group's `grp_gate` returns to 1.
- R11: A group's gate changes state only while that group's clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, released per clock domain |
| cpu_clk | input | 1 | CPU clock used to sample the control pin |
| grp_clk | input | NGRP | Free-running clock of each output group (bit 0 is the CPU clock) |
| pwrgd_pd_n | input | 1 | Power-good rise before capture; active-low power-down request afterwards |
| strap_in | input | FSEL_W | Levels on the shared strap pins |
| fsel_code | output | FSEL_W | Stored frequency-select code |
| pins_oe | output | 1 | 1 once the shared pins are switched to clock outputs |
| grp_gate | output | NGRP | Latched run state of each group's gate |
| grp_clk_out | output | NGRP | Glitch-free gated clock of each group |

## Verification
The hardest case to reach is a power-down request that lasts exactly two CPU sampling edges. It qualifies, but it is withdrawn one cycle later, so the run enable drops for a single cycle and group 0 must lose exactly one high phase. The bench reaches it by moving the pin just after a CPU rising edge and counting gated high phases edge by edge. Single-edge pulses and sustained lows are applied in the same way. Each round uses new random strap codes, random gaps and a fresh reset. A pulse-width monitor on every gated output runs throughout, so any runt produced by the asynchronous slow groups is caught.

// File: rtl/strap_pd_pkg.sv
package strap_pd_pkg;
  localparam int FSEL_W_DEF      = 5;
  localparam int NGRP_DEF        = 4;
  localparam int SYNC_STAGES_DEF = 2;
  localparam int QUAL_CNT_DEF    = 2;

  typedef enum logic {
    PIN_SENSE = 1'b0,
    PIN_DRIVE = 1'b1
  } pin_dir_e;
endpackage

// File: rtl/strap_pd_rst_sync.sv
module strap_pd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/strap_pd_ctrl.sv
module strap_pd_ctrl
  import strap_pd_pkg::*;
#(
  parameter int FSEL_W      = FSEL_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int QUAL_CNT    = QUAL_CNT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_raw,
  input  logic [FSEL_W-1:0] strap_in,
  output logic [FSEL_W-1:0] fsel_code,
  output logic              pins_oe,
  output logic              run_en
);
  localparam int CNT_W = (QUAL_CNT > 2) ? $clog2(QUAL_CNT) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CNT - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   pin_s;
  pin_dir_e               dir_q, dir_d;
  logic [FSEL_W-1:0]      fsel_q;
  logic                   cap_en;
  logic [CNT_W-1:0]       low_q, low_d;
  logic                   qualified;
  logic                   run_q, run_d;

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d    = {sync_q[SYNC_STAGES-2:0], pin_raw};
    cap_en    = (dir_q == PIN_SENSE) && pin_s;
    dir_d     = cap_en ? PIN_DRIVE : dir_q;
    if ((dir_q == PIN_SENSE) || pin_s)   low_d = '0;
    else if (low_q != CNT_MAX)           low_d = low_q + 1'b1;
    else                                 low_d = low_q;
    qualified = (dir_q == PIN_DRIVE) && !pin_s && (low_q == CNT_MAX);
    run_d     = (dir_q == PIN_DRIVE) && !qualified;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      dir_q  <= PIN_SENSE;
      low_q  <= '0;
      run_q  <= 1'b0;
    end else begin
      sync_q <= sync_d;
      dir_q  <= dir_d;
      low_q  <= low_d;
      run_q  <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fsel_q <= '0;
    else if (cap_en) fsel_q <= strap_in;
  end

  assign fsel_code = fsel_q;
  assign pins_oe   = (dir_q == PIN_DRIVE);
  assign run_en    = run_q;

  assert_strap_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == PIN_DRIVE) |=> ($stable(fsel_q) && (dir_q == PIN_DRIVE)));

  assert_run_after_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (dir_q == PIN_DRIVE));

  generate
    if (QUAL_CNT == 2) begin : g_two_sample
      assert_two_low_samples_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_q) |-> (!$past(pin_s) && !$past(pin_s, 2)));
    end
  endgenerate
endmodule

// File: rtl/strap_pd_clk_gate.sv
module strap_pd_clk_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic gate,
  output logic clk_out
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   run_s;
  logic                   gate_l;

  assign run_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], run_en};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  always_latch begin
    if (!rst_n)   gate_l <= 1'b0;
    else if (!clk) gate_l <= run_s;
  end

  assign gate    = gate_l;
  assign clk_out = clk & gate_l;

  assert_gate_moves_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gate_l == run_s);
endmodule

// File: rtl/strap_pd_seq.sv
module strap_pd_seq
  import strap_pd_pkg::*;
#(
  parameter int FSEL_W      = FSEL_W_DEF,
  parameter int NGRP        = NGRP_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF,
  parameter int QUAL_CNT    = QUAL_CNT_DEF
) (
  input  logic              rst_n,
  input  logic              cpu_clk,
  input  logic [NGRP-1:0]   grp_clk,
  input  logic              pwrgd_pd_n,
  input  logic [FSEL_W-1:0] strap_in,
  output logic [FSEL_W-1:0] fsel_code,
  output logic              pins_oe,
  output logic [NGRP-1:0]   grp_gate,
  output logic [NGRP-1:0]   grp_clk_out
);
  logic cpu_srst_n;
  logic run_en;

  strap_pd_rst_sync #(.STAGES(SYNC_STAGES)) u_cpu_rst (
    .clk    (cpu_clk),
    .arst_n (rst_n),
    .srst_n (cpu_srst_n)
  );

  strap_pd_ctrl #(
    .FSEL_W      (FSEL_W),
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CNT    (QUAL_CNT)
  ) u_ctrl (
    .clk       (cpu_clk),
    .rst_n     (cpu_srst_n),
    .pin_raw   (pwrgd_pd_n),
    .strap_in  (strap_in),
    .fsel_code (fsel_code),
    .pins_oe   (pins_oe),
    .run_en    (run_en)
  );

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
      logic grp_srst_n;

      strap_pd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
        .clk    (grp_clk[g]),
        .arst_n (rst_n),
        .srst_n (grp_srst_n)
      );

      strap_pd_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
        .clk     (grp_clk[g]),
        .rst_n   (grp_srst_n),
        .run_en  (run_en),
        .gate    (grp_gate[g]),
        .clk_out (grp_clk_out[g])
      );
    end
  endgenerate
endmodule

// File: tb/strap_pd_seq_bench.sv
`timescale 1ns/1ps
module strap_pd_seq_bench;
  localparam int FSEL_W = 5;
  localparam int NGRP   = 4;

  logic              rst_n;
  logic              cpu_clk;
  logic              g1_clk, g2_clk, g3_clk;
  logic [NGRP-1:0]   grp_clk;
  logic              pwrgd_pd_n;
  logic [FSEL_W-1:0] strap_in;
  logic [FSEL_W-1:0] fsel_code;
  logic              pins_oe;
  logic [NGRP-1:0]   grp_gate;
  logic [NGRP-1:0]   grp_clk_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done_flag = 0;

  strap_pd_seq u_strap_pd_seq (
    .rst_n       (rst_n),
    .cpu_clk     (cpu_clk),
    .grp_clk     (grp_clk),
    .pwrgd_pd_n  (pwrgd_pd_n),
    .strap_in    (strap_in),
    .fsel_code   (fsel_code),
    .pins_oe     (pins_oe),
    .grp_gate    (grp_gate),
    .grp_clk_out (grp_clk_out)
  );

  initial cpu_clk = 0;
  always #2 cpu_clk = ~cpu_clk;
  initial g1_clk = 0;
  always #3 g1_clk = ~g1_clk;
  initial g2_clk = 0;
  always #5 g2_clk = ~g2_clk;
  initial g3_clk = 0;
  always #7 g3_clk = ~g3_clk;
  assign grp_clk = {g3_clk, g2_clk, g1_clk, cpu_clk};

  function automatic real half_period(int g);
    case (g)
      0: return 2.0;
      1: return 3.0;
      2: return 5.0;
      default: return 7.0;
    endcase
  endfunction

  // R9 pulse-width monitor on every gated output
  generate
    for (genvar gi = 0; gi < NGRP; gi++) begin : g_mon
      real t_rise = -1.0;
      int  runts  = 0;
      int  pulses = 0;
      always @(posedge grp_clk_out[gi]) t_rise = $realtime;
      always @(negedge grp_clk_out[gi]) begin
        if (t_rise >= 0.0) begin
          pulses++;
          if (($realtime - t_rise) < half_period(gi) - 0.01 ||
              ($realtime - t_rise) > half_period(gi) + 0.01) begin
            runts++;
            $display("FAIL R9 group %0d actual=%0.3f expected=%0.3f",
                     gi, $realtime - t_rise, half_period(gi));
          end
        end
      end
    end
  endgenerate

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(posedge cpu_clk);
    #1;
  endtask

  // pin rise, capture and first pulse (R3, R5)
  task automatic power_up(logic [FSEL_W-1:0] code);
    int first;
    strap_in = code;
    @(negedge cpu_clk);
    pwrgd_pd_n = 1;
    first = 0;
    for (int e = 1; e <= 10; e++) begin
      @(posedge cpu_clk); #1;
      if (e == 2) begin
        chk("R3 fsel before capture", fsel_code, 0);
        chk("R3 oe before capture", pins_oe, 0);
      end
      if (e == 3) begin
        chk("R3 fsel captured", fsel_code, code);
        chk("R3 oe raised", pins_oe, 1);
      end
      if (first == 0 && grp_clk_out[0]) first = e;
    end
    chk("R5 first group0 pulse edge", first, 7);
    wait_cyc(30);
    chk("R5 all gates open", grp_gate, {NGRP{1'b1}});
  endtask

  task automatic short_pulse(int len, logic [FSEL_W-1:0] code);
    int highs;
    bit any_drop;
    logic [12:0] hi;
    @(posedge cpu_clk); #1;
    pwrgd_pd_n = 0;
    highs = 0; any_drop = 0; hi = '0;
    for (int e = 1; e <= 12; e++) begin
      @(posedge cpu_clk); #1;
      hi[e] = grp_clk_out[0];
      if (grp_clk_out[0]) highs++;
      if (grp_gate != {NGRP{1'b1}}) any_drop = 1;
      if (e == len) pwrgd_pd_n = 1;
    end
    if (len == 1) begin
      chk("R6 group0 highs", highs, 12);
      chk("R6 no gate dropped", any_drop, 0);
    end else begin
      chk("R8 group0 highs", highs, 11);
      chk("R8 missing phase at edge7", hi[7], 0);
    end
    chk("R4 fsel held", fsel_code, code);
    wait_cyc(25 + $urandom_range(0, 10));
    chk("R8 gates reopen", grp_gate, {NGRP{1'b1}});
  endtask

  task automatic sustained(logic [FSEL_W-1:0] code);
    int highs, last, first;
    @(posedge cpu_clk); #1;
    pwrgd_pd_n = 0;
    highs = 0; last = 0;
    for (int e = 1; e <= 10; e++) begin
      @(posedge cpu_clk); #1;
      if (grp_clk_out[0]) begin highs++; last = e; end
    end
    chk("R7 group0 highs", highs, 6);
    chk("R7 last group0 edge", last, 6);
    wait_cyc(30);
    chk("R7 gates closed", grp_gate, 0);
    chk("R7 outputs low", grp_clk_out, 0);
    wait_cyc(3);
    chk("R7 outputs still low", grp_clk_out, 0);
    chk("R4 oe held", pins_oe, 1);
    pwrgd_pd_n = 1;
    first = 0;
    for (int e = 1; e <= 10; e++) begin
      @(posedge cpu_clk); #1;
      if (first == 0 && grp_clk_out[0]) first = e;
    end
    chk("R10 restart edge", first, 6);
    wait_cyc(30);
    chk("R10 gates reopen", grp_gate, {NGRP{1'b1}});
    chk("R4 fsel after restart", fsel_code, code);
  endtask

  initial begin
    logic [FSEL_W-1:0] code;
    int pre_pulses;
    void'($urandom(32'h00C0FFEE));
    rst_n = 0;
    pwrgd_pd_n = 0;
    strap_in = '0;
    #20;
    chk("R1 fsel", fsel_code, 0);
    chk("R1 oe", pins_oe, 0);
    chk("R1 gates", grp_gate, 0);
    chk("R1 outputs", grp_clk_out, 0);
    @(negedge cpu_clk);
    rst_n = 1;
    strap_in = 5'h1F;
    wait_cyc(20);
    chk("R2 oe", pins_oe, 0);
    chk("R2 fsel", fsel_code, 0);
    pre_pulses = g_mon[0].pulses + g_mon[1].pulses + g_mon[2].pulses + g_mon[3].pulses;
    chk("R2 no pulses", pre_pulses, 0);

    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin
        pwrgd_pd_n = 0;
        wait_cyc(40);
        rst_n = 0;
        #10;
        chk("R1 reset fsel", fsel_code, 0);
        chk("R1 reset oe", pins_oe, 0);
        chk("R1 reset gates", grp_gate, 0);
        @(negedge cpu_clk);
        rst_n = 1;
        wait_cyc(8);
      end
      case (k)
        0: code = 5'h00;
        1: code = 5'h1F;
        default: code = FSEL_W'($urandom_range(0, 31));
      endcase
      power_up(code);
      strap_in = ~code;
      wait_cyc($urandom_range(2, 12));
      chk("R4 strap change ignored", fsel_code, code);
      if ($urandom_range(0, 1) == 1) begin
        short_pulse(1, code);
        short_pulse(2, code);
      end else begin
        short_pulse(2, code);
        short_pulse(1, code);
      end
      sustained(code);
    end

    pwrgd_pd_n = 0;
    wait_cyc(40);
    chk("R9 runts group0", g_mon[0].runts, 0);
    chk("R9 runts group1", g_mon[1].runts, 0);
    chk("R9 runts group2", g_mon[2].runts, 0);
    chk("R9 runts group3", g_mon[3].runts, 0);
    chk("R9 group3 pulsed", g_mon[3].pulses > 0, 1);
    finish_run();
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule